// File: doc/BRIEF.md
# Function-Coded Arithmetic/Logic Unit with Condition Flags

This block is the arithmetic and logic stage of a 32-bit datapath. A six-bit function code selects the operation. Operand A and operand B can each be complemented, and the complemented values feed both the bitwise logic unit and a two's-complement adder. A result multiplexer then chooses either the logic output or the sum. The result is purely combinational and follows the operands and the code within the same cycle.

The four condition flags are negative, zero, carry and overflow. They are held in a small register. On a clock edge where the flag write enable is high and the code is a defined one, the flags take new values. Negative and zero follow the result for every defined code. Carry and overflow change only for the three adder codes and keep their previous values for logic codes. An undefined code drives a zero result and leaves every flag untouched.

Top module: `fcalu_top`

## Requirements
- R1: Code 000100 (bit 5 down to bit 0) gives A AND B, code 001000 gives A AND NOT B, and code 001001 gives A XOR B, on `result` in the same cycle.
- R2: Code 000000 passes A, 000001 gives A OR B, 000101 passes B, 001010 gives NOT B, and 001100 gives all zeros, regardless of the operand values.
- R3: Code 010110 gives A + B + `carry_in`, taken modulo 2^32.
- R4: Code 011001 gives A + NOT B + `carry_in`, so it yields A - B when `carry_in` is 1.
- R5: Code 110110 gives NOT A + B + `carry_in`, so it yields B - A when `carry_in` is 1.
- R6: At a rising edge with `flag_we` = 1 and a defined code, `flag_n` takes result bit 31 and `flag_z` becomes 1 exactly when the result is all zeros. The new values are visible after that edge.
- R7: For an adder code written with `flag_we` = 1, `flag_c` takes the adder carry out of bit 31. `flag_v` becomes 1 when both adder inputs, after complementing, have the same sign and the sum has the opposite sign.
- R8: For a logic code written with `flag_we` = 1, `flag_c` and `flag_v` keep their previous values while N and Z update.
- R9: With `flag_we` = 0, all four flags stay unchanged whatever the code and operands are.
- R10: Any code not listed in R1 to R5 gives a zero result and leaves all four flags unchanged, even with `flag_we` = 1.
- R11: A rising edge with `rst_n` = 0 clears all four flags to 0 (synchronous, active-low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| flag_we | input | 1 | Flag write enable for the current operation |
| fcode | input | 6 | Function code |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| carry_in | input | 1 | Carry input to the adder |
| result | output | 32 | Combinational result |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
The bench builds the block with its default width of 32. At that width the sign boundary sits at 0x7FFFFFFF/0x80000000 and the carry boundary sits at 0xFFFFFFFF. Operands placed at these boundaries produce signed overflow in both directions, a carry out together with a zero result, and subtraction with and without a borrow. Logic codes are issued right after adder codes that leave carry and overflow set, so that a logic code which wrongly updates those flags is detected. Undefined codes and writes with the enable low are issued while the stored flags are not zero.

// File: rtl/fcalu_pkg.sv
// Package: shared function codes and the decoded control word of the ALU.
// Assumes a six-bit function code; the bit meanings are set by the decoder.
package fcalu_pkg;

    localparam int unsigned FCODE_W = 6;

    // Defined function codes.
    localparam logic [FCODE_W-1:0] FC_PASS_A = 6'b000000;
    localparam logic [FCODE_W-1:0] FC_OR     = 6'b000001;
    localparam logic [FCODE_W-1:0] FC_AND    = 6'b000100;
    localparam logic [FCODE_W-1:0] FC_PASS_B = 6'b000101;
    localparam logic [FCODE_W-1:0] FC_ANDN   = 6'b001000;
    localparam logic [FCODE_W-1:0] FC_XOR    = 6'b001001;
    localparam logic [FCODE_W-1:0] FC_NOT_B  = 6'b001010;
    localparam logic [FCODE_W-1:0] FC_ZERO   = 6'b001100;
    localparam logic [FCODE_W-1:0] FC_ADD    = 6'b010110;
    localparam logic [FCODE_W-1:0] FC_SUB    = 6'b011001;
    localparam logic [FCODE_W-1:0] FC_RSUB   = 6'b110110;

    // Bitwise function applied to the (possibly complemented) operands.
    typedef enum logic [2:0] {
        LG_ZERO = 3'd0,
        LG_AND  = 3'd1,
        LG_OR   = 3'd2,
        LG_XOR  = 3'd3,
        LG_A    = 3'd4,
        LG_B    = 3'd5
    } logic_sel_e;

    // Decoded control word.
    typedef struct packed {
        logic       valid;   // code is one of the defined set
        logic       arith;   // result taken from the adder
        logic       inv_a;   // complement operand A
        logic       inv_b;   // complement operand B
        logic       cin_en;  // carry input reaches the adder
        logic_sel_e lsel;    // bitwise function
    } fcalu_ctrl_t;

endpackage

// File: rtl/fcalu_decode.sv
// Module: fcalu_decode
// Turns the six-bit function code into the control word that steers the
// operand complementers, the bitwise unit, the adder carry and the result
// multiplexer. It is purely combinational. Any code outside the defined set
// gives a control word with valid = 0, and the datapath then drives zero.
module fcalu_decode
    import fcalu_pkg::*;
(
    input  logic [FCODE_W-1:0] fcode,
    output fcalu_ctrl_t        ctrl
);

    // Purpose: map each defined code to its control settings.
    always_comb begin
        ctrl = '0;
        ctrl.lsel = LG_ZERO;
        unique case (fcode)
            FC_PASS_A: begin ctrl.valid = 1'b1; ctrl.lsel = LG_A;    end
            FC_OR:     begin ctrl.valid = 1'b1; ctrl.lsel = LG_OR;   end
            FC_AND:    begin ctrl.valid = 1'b1; ctrl.lsel = LG_AND;  end
            FC_PASS_B: begin ctrl.valid = 1'b1; ctrl.lsel = LG_B;    end
            FC_ANDN:   begin ctrl.valid = 1'b1; ctrl.lsel = LG_AND;
                             ctrl.inv_b = 1'b1;                     end
            FC_XOR:    begin ctrl.valid = 1'b1; ctrl.lsel = LG_XOR;  end
            FC_NOT_B:  begin ctrl.valid = 1'b1; ctrl.lsel = LG_B;
                             ctrl.inv_b = 1'b1;                     end
            FC_ZERO:   begin ctrl.valid = 1'b1; ctrl.lsel = LG_ZERO; end
            FC_ADD:    begin ctrl.valid = 1'b1; ctrl.arith = 1'b1;
                             ctrl.cin_en = 1'b1;                    end
            FC_SUB:    begin ctrl.valid = 1'b1; ctrl.arith = 1'b1;
                             ctrl.cin_en = 1'b1; ctrl.inv_b = 1'b1; end
            FC_RSUB:   begin ctrl.valid = 1'b1; ctrl.arith = 1'b1;
                             ctrl.cin_en = 1'b1; ctrl.inv_a = 1'b1; end
            default:   ctrl = '0;
        endcase
    end

endmodule

// File: rtl/fcalu_datapath.sv
// Module: fcalu_datapath
// XOR-based operand complementers feed both a per-bit logic unit and a
// two's-complement adder. A result multiplexer then picks the sum or the
// logic output, or zero for an undefined code. The module also produces the
// adder carry out and the signed overflow. It is purely combinational and
// assumes WIDTH >= 2.
module fcalu_datapath
    import fcalu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  fcalu_ctrl_t      ctrl,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             ovf
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] opa, opb, lres;
    logic [WIDTH:0]   sum_ext;
    logic             cin_eff;

    // Purpose: one bit of the bitwise function.
    function automatic logic lbit(input logic_sel_e sel, input logic x, input logic y);
        case (sel)
            LG_AND:  return x & y;
            LG_OR:   return x | y;
            LG_XOR:  return x ^ y;
            LG_A:    return x;
            LG_B:    return y;
            default: return 1'b0;
        endcase
    endfunction

    // Purpose: complement the operands through XOR gates.
    assign opa = a ^ {WIDTH{ctrl.inv_a}};
    assign opb = b ^ {WIDTH{ctrl.inv_b}};

    // Purpose: one logic cell per result bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_lcell
        assign lres[i] = lbit(ctrl.lsel, opa[i], opb[i]);
    end

    // Purpose: gate the carry input and form the full-width sum.
    assign cin_eff = cin & ctrl.cin_en;
    assign sum_ext = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin_eff};

    // Purpose: carry out and signed overflow of the adder.
    assign cout = sum_ext[WIDTH];
    assign ovf  = (opa[MSB] == opb[MSB]) && (sum_ext[MSB] != opa[MSB]);

    // Purpose: result multiplexer.
    always_comb begin
        if (!ctrl.valid)     res = '0;
        else if (ctrl.arith) res = sum_ext[MSB:0];
        else                 res = lres;
    end

endmodule

// File: rtl/fcalu_flags.sv
// Module: fcalu_flags
// Holds the N, Z, C and V condition flags. It writes them on a clock edge
// with the write enable high and a defined code. N and Z always update on a
// write. C and V update only for adder codes. Reset is synchronous and
// active-low. Assumes res, cout and ovf are settled before the clock edge.
module fcalu_flags #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             valid,
    input  logic             arith,
    input  logic [WIDTH-1:0] res,
    input  logic             cout,
    input  logic             ovf,
    output logic             n_q,
    output logic             z_q,
    output logic             c_q,
    output logic             v_q
);

    logic wr_nz, wr_cv;

    // Purpose: decide which flag pairs are written this cycle.
    assign wr_nz = we & valid;
    assign wr_cv = we & valid & arith;

    // Purpose: flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= 1'b0;
            z_q <= 1'b0;
            c_q <= 1'b0;
            v_q <= 1'b0;
        end else begin
            if (wr_nz) begin
                n_q <= res[WIDTH-1];
                z_q <= ~|res;
            end
            if (wr_cv) begin
                c_q <= cout;
                v_q <= ovf;
            end
        end
    end

    // R11: reset clears every flag.
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> ({n_q, z_q, c_q, v_q} == 4'b0000));

    // R9: no write enable, no flag change.
    a_r9_we_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable({n_q, z_q, c_q, v_q}));

    // R10: undefined code never touches the flags.
    a_r10_undef_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !valid) |=> $stable({n_q, z_q, c_q, v_q}));

    // R8: logic codes keep carry and overflow.
    a_r8_logic_cv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (we && valid && !arith) |=> $stable({c_q, v_q}));

    // R6: negative flag follows the sign of the written result.
    a_r6_n_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (we && valid) |=> (n_q == $past(res[WIDTH-1])));

endmodule

// File: rtl/fcalu_top.sv
// Module: fcalu_top
// Function-coded arithmetic/logic unit with stored condition flags. It
// connects the code decoder, the datapath and the flag register. The result
// is combinational. The flags change only at clock edges.
module fcalu_top
    import fcalu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flag_we,
    input  logic [FCODE_W-1:0] fcode,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    input  logic               carry_in,
    output logic [WIDTH-1:0]   result,
    output logic               flag_n,
    output logic               flag_z,
    output logic               flag_c,
    output logic               flag_v
);

    fcalu_ctrl_t ctrl;
    logic        add_cout, add_ovf;

    fcalu_decode u_dec (
        .fcode (fcode),
        .ctrl  (ctrl)
    );

    fcalu_datapath #(.WIDTH(WIDTH)) u_dp (
        .ctrl (ctrl),
        .a    (op_a),
        .b    (op_b),
        .cin  (carry_in),
        .res  (result),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    fcalu_flags #(.WIDTH(WIDTH)) u_flg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we),
        .valid (ctrl.valid),
        .arith (ctrl.arith),
        .res   (result),
        .cout  (add_cout),
        .ovf   (add_ovf),
        .n_q   (flag_n),
        .z_q   (flag_z),
        .c_q   (flag_c),
        .v_q   (flag_v)
    );

endmodule

// File: tb/sim_fcalu_top.sv
`timescale 1ns/1ps
// Scoreboard bench for fcalu_top. The driver applies one operation per
// cycle at the falling edge and queues its expected result and flags. The
// monitor compares them just after the following rising edge.
module sim_fcalu_top;

    typedef struct {
        logic [31:0] res;
        logic [3:0]  nzcv;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_we = 1'b0;
    logic [5:0]  fcode = 6'd0;
    logic [31:0] op_a = 32'd0, op_b = 32'd0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_c, flag_v;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t sb[$];
    logic [3:0] mflags = 4'b0000;   // model of N,Z,C,V

    always #2 clk = ~clk;

    fcalu_top #(.WIDTH(32)) u0 (
        .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .fcode(fcode),
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    // Reference adder: {overflow, carry, sum} from a signed wide sum.
    function automatic logic [33:0] ref_add(input logic [31:0] p, input logic [31:0] q, input logic ci);
        logic [32:0]        u;
        logic signed [33:0] s;
        logic               ov;
        u  = {1'b0, p} + {1'b0, q} + {32'd0, ci};
        s  = $signed({{2{p[31]}}, p}) + $signed({{2{q[31]}}, q}) + $signed({33'd0, ci});
        ov = (s > 34'sd2147483647) || (s < -34'sd2147483648);
        return {ov, u[32], u[31:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply an operation and queue its expected outcome.
    task automatic drive(input logic [5:0] code, input logic [31:0] x, input logic [31:0] y,
                         input logic ci, input logic we, input string tag);
        logic [31:0] r;
        logic [33:0] ar;
        logic        ok, is_ar;
        exp_t        e;
        ok = 1'b1; is_ar = 1'b0; r = 32'd0; ar = 34'd0;
        case (code)
            6'b000000: r = x;
            6'b000001: r = x | y;
            6'b000100: r = x & y;
            6'b000101: r = y;
            6'b001000: r = x & ~y;
            6'b001001: r = x ^ y;
            6'b001010: r = ~y;
            6'b001100: r = 32'd0;
            6'b010110: begin is_ar = 1'b1; ar = ref_add(x, y, ci);  end
            6'b011001: begin is_ar = 1'b1; ar = ref_add(x, ~y, ci); end
            6'b110110: begin is_ar = 1'b1; ar = ref_add(~x, y, ci); end
            default:   ok = 1'b0;
        endcase
        if (is_ar) r = ar[31:0];
        if (we && ok) begin
            mflags[3] = r[31];
            mflags[2] = (r == 32'd0);
            if (is_ar) mflags[1:0] = ar[32 +: 2] >> 0 == 2'b00 ? 2'b00 : {ar[32], ar[33]};
        end
        @(negedge clk);
        fcode = code; op_a = x; op_b = y; carry_in = ci; flag_we = we;
        e.res = r; e.nzcv = mflags; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, result, e.res, "result");
                check(e.tag, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, e.nzcv}, "flags");
            end
        end
    end

    // Watchdog.
    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset with an add pending must leave the flags clear.
        fcode = 6'b010110; op_a = 32'hFFFF_FFFF; op_b = 32'd1; flag_we = 1'b1;
        repeat (3) @(negedge clk);
        check("R11", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0, "reset flags");
        rst_n = 1'b1;

        // R3, R7: addition, carry and overflow boundaries.
        drive(6'b010110, 32'd1, 32'd2, 1'b0, 1'b1, "R3");
        drive(6'b010110, 32'd5, 32'd6, 1'b1, 1'b1, "R3");
        drive(6'b010110, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b1, "R7");
        drive(6'b010110, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, "R7");
        drive(6'b010110, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, "R7");
        // R4: subtraction with and without borrow, signed overflow.
        drive(6'b011001, 32'd10, 32'd3, 1'b1, 1'b1, "R4");
        drive(6'b011001, 32'd3, 32'd10, 1'b1, 1'b1, "R4");
        drive(6'b011001, 32'h8000_0000, 32'd1, 1'b1, 1'b1, "R4");
        drive(6'b011001, 32'h1234_5678, 32'h1234_5678, 1'b1, 1'b1, "R6");
        // R5: reverse subtract.
        drive(6'b110110, 32'd3, 32'd10, 1'b1, 1'b1, "R5");
        drive(6'b110110, 32'd0, 32'd0, 1'b0, 1'b1, "R5");
        // R8: set C=1,V=1 then run logic codes.
        drive(6'b011001, 32'h8000_0000, 32'd1, 1'b1, 1'b1, "R7");
        drive(6'b000100, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b0, 1'b1, "R8");
        drive(6'b000100, 32'hFF00_FF00, 32'hF0F0_F0F0, 1'b0, 1'b1, "R1");
        drive(6'b001000, 32'hFFFF_0000, 32'h0F0F_0F0F, 1'b0, 1'b1, "R1");
        drive(6'b001001, 32'hAAAA_5555, 32'hFFFF_0000, 1'b1, 1'b1, "R1");
        drive(6'b000001, 32'h0000_00F0, 32'h8000_000F, 1'b0, 1'b1, "R2");
        drive(6'b000000, 32'hDEAD_BEEF, 32'h0, 1'b0, 1'b1, "R2");
        drive(6'b000101, 32'hDEAD_BEEF, 32'h0000_1234, 1'b0, 1'b1, "R2");
        drive(6'b001010, 32'h0, 32'h0000_FFFF, 1'b0, 1'b1, "R2");
        drive(6'b001100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, "R2");
        // R9: adds with write enable low.
        drive(6'b010110, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b1, "R7");
        drive(6'b010110, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R9");
        drive(6'b001100, 32'd1, 32'd1, 1'b0, 1'b0, "R9");
        // R10: undefined codes.
        drive(6'b111111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, "R10");
        drive(6'b010111, 32'h1234_5678, 32'h0000_0001, 1'b0, 1'b1, "R10");
        drive(6'b000010, 32'hFFFF_FFFF, 32'd0, 1'b0, 1'b1, "R10");
        // Wait for the queue to drain, then reset mid-run.
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0, "mid-run reset");
        rst_n = 1'b1;
        mflags = 4'b0000;
        drive(6'b010110, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, "R6");
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule